// File: doc/BRIEF.md
# SPI Receive Word Buffer with Overrun Status

This block sits behind a serial shift engine and holds the most recent complete receive word. Each time the engine pulses its word-done strobe, the word is copied into the buffer and a received-flag is raised. If the previous word was never taken through a buffer read, an overrun flag is raised as well. The new word always replaces the old one.

Two read ports share the stored word. A clearing read returns the word with both flag images packed above it, and it drops both flags and the internal valid marker. A debug read returns the same word and changes nothing. Both flags can also be dropped with write-one-to-clear strobes and by taking the enable low. A receive interrupt follows the received-flag, gated by an interrupt enable.

The internal valid marker is cleared only by a clearing read or by reset. It persists across a disable and re-enable cycle, so the first word after re-enabling reports an overrun unless software performs a dummy clearing read first.

Top module: `spi_rxbuf_status`

## Requirements
- R1: While `en_i` is 1, a `word_done_i` pulse loads `word_i` into the buffer at that clock edge. At any other edge the stored word holds.
- R2: A clearing read (`buf_rd_i`=1) without a same-cycle accepted word clears both flags and the valid marker at that edge.
- R3: While `buf_rd_i` is 1, `buf_rdata_o` carries the stored word in bits DATA_W-1:0, the received-flag in bit DATA_W (bit 16 by default), and the overrun flag in bit DATA_W+1 (bit 17 by default). While `buf_rd_i` is 0, `buf_rdata_o` is 0.
- R4: While `dbg_rd_i` is 1, `dbg_rdata_o` equals the stored word, and a debug read leaves both flags and the valid marker unchanged. While `dbg_rd_i` is 0, `dbg_rdata_o` is 0.
- R5: An accepted word that arrives while the valid marker is set, with no same-cycle clearing read, sets the overrun flag.
- R6: Taking `en_i` low does not clear the valid marker. After re-enabling, the first accepted word raises overrun unless a clearing read came first.
- R7: `rxf_clr_i`=1 clears the received-flag and `ovr_clr_i`=1 clears the overrun flag. A same-cycle set condition takes priority over either clear.
- R8: While `en_i` is 0, both flags are cleared at every edge and `word_done_i` is ignored.
- R9: When a clearing read and an accepted word share a cycle, the new word is stored, the received-flag ends at 1 and the overrun flag ends at 0.
- R10: `irq_o` is 1 exactly when the received-flag is 1 and `irq_en_i` is 1.
- R11: After a synchronous reset, the stored word, both flags and the valid marker are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Receive enable |
| irq_en_i | input | 1 | Receive interrupt enable |
| word_done_i | input | 1 | Word-complete strobe from the shift engine |
| word_i | input | DATA_W | Completed word from the shift engine |
| buf_rd_i | input | 1 | Clearing read strobe |
| dbg_rd_i | input | 1 | Side-effect-free read strobe |
| rxf_clr_i | input | 1 | Write-one clear of the received-flag |
| ovr_clr_i | input | 1 | Write-one clear of the overrun flag |
| buf_rdata_o | output | DATA_W+2 | Clearing-read data: overrun, received-flag, word |
| dbg_rdata_o | output | DATA_W | Debug-read data |
| irq_o | output | 1 | Receive interrupt |

## Verification
The embedded assertions check on every cycle that the word changes only on an accepted strobe, that a clearing read or a disable drops the flags, that an accepted word always raises the received-flag, and that overrun rises only when the valid marker was set. Only the bench scenarios can show the rest. These cover the spurious overrun after a disable and re-enable cycle, the priority when a read and a word coincide, the absence of side effects from repeated debug reads, and the exact packing of the flag images. A bench model is compared against every output on every cycle of a seeded random run.

// File: rtl/spi_rxbuf_pkg.sv
package spi_rxbuf_pkg;

    typedef struct packed {
        logic rxf;   // received-flag
        logic ovr;   // overrun flag
        logic vld;   // internal unread-data marker
    } rx_flags_t;

    typedef enum logic [1:0] {
        EV_NONE     = 2'd0,
        EV_LOAD     = 2'd1,
        EV_LOAD_OVR = 2'd2
    } rx_event_t;

    // Classify what an incoming strobe does to the status
    function automatic rx_event_t classify_event(input logic accept,
                                                 input logic vld,
                                                 input logic rd);
        if (!accept)
            return EV_NONE;
        else if (vld && !rd)
            return EV_LOAD_OVR;
        else
            return EV_LOAD;
    endfunction

    function automatic rx_flags_t next_flags(input rx_flags_t cur,
                                             input logic      en,
                                             input rx_event_t ev,
                                             input logic      rd,
                                             input logic      rxf_clr,
                                             input logic      ovr_clr);
        rx_flags_t n;
        n = cur;
        // valid marker: only a load or a clearing read touches it
        if (ev != EV_NONE)
            n.vld = 1'b1;
        else if (rd)
            n.vld = 1'b0;
        if (!en) begin
            n.rxf = 1'b0;
            n.ovr = 1'b0;
        end else begin
            if (ev != EV_NONE)
                n.rxf = 1'b1;
            else if (rd || rxf_clr)
                n.rxf = 1'b0;
            if (ev == EV_LOAD_OVR)
                n.ovr = 1'b1;
            else if (rd || ovr_clr)
                n.ovr = 1'b0;
        end
        return n;
    endfunction

endpackage

// File: rtl/rxbuf_data_reg.sv
module rxbuf_data_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (load_i)
            data_q <= word_i;
    end

    assign data_o = data_q;

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(data_o)); // R1

    AST_DATA_LOADS: assert property (@(posedge clk) disable iff (rst)
        load_i |=> data_o == $past(word_i)); // R1

endmodule

// File: rtl/rxbuf_flag_ctrl.sv
module rxbuf_flag_ctrl
    import spi_rxbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  logic      done_i,
    input  logic      rd_i,
    input  logic      rxf_clr_i,
    input  logic      ovr_clr_i,
    output rx_flags_t flags_o,
    output logic      accept_o
);

    rx_flags_t flags_q;
    rx_flags_t flags_d;
    rx_event_t ev;
    logic      accept;

    assign accept = done_i && en_i;
    assign ev     = classify_event(accept, flags_q.vld, rd_i);

    always_comb begin
        flags_d = next_flags(flags_q, en_i, ev, rd_i, rxf_clr_i, ovr_clr_i);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags_o  = flags_q;
    assign accept_o = accept;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_i && !accept |=> !flags_o.rxf && !flags_o.ovr && !flags_o.vld); // R2

    AST_ACCEPT_SETS_RXF: assert property (@(posedge clk) disable iff (rst)
        accept |=> flags_o.rxf && flags_o.vld); // R7

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o.ovr) |-> $past(flags_o.vld) && $past(accept) && !$past(rd_i)); // R5

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !flags_o.rxf && !flags_o.ovr); // R8

    AST_VLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        flags_o.vld && !rd_i |=> flags_o.vld); // R6

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_i && accept |=> flags_o.rxf && !flags_o.ovr); // R9

endmodule

// File: rtl/spi_rxbuf_status.sv
module spi_rxbuf_status
    import spi_rxbuf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              irq_en_i,
    input  logic              word_done_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              buf_rd_i,
    input  logic              dbg_rd_i,
    input  logic              rxf_clr_i,
    input  logic              ovr_clr_i,
    output logic [DATA_W+1:0] buf_rdata_o,
    output logic [DATA_W-1:0] dbg_rdata_o,
    output logic              irq_o
);

    localparam int RXF_BIT = DATA_W;
    localparam int OVR_BIT = DATA_W + 1;

    rx_flags_t         flags;
    logic              accept;
    logic [DATA_W-1:0] data;

    rxbuf_flag_ctrl u_flags (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .done_i    (word_done_i),
        .rd_i      (buf_rd_i),
        .rxf_clr_i (rxf_clr_i),
        .ovr_clr_i (ovr_clr_i),
        .flags_o   (flags),
        .accept_o  (accept)
    );

    rxbuf_data_reg #(.DATA_W(DATA_W)) u_data (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .word_i (word_i),
        .data_o (data)
    );

    always_comb begin
        buf_rdata_o = '0;
        if (buf_rd_i) begin
            buf_rdata_o[DATA_W-1:0] = data;
            buf_rdata_o[RXF_BIT]    = flags.rxf;
            buf_rdata_o[OVR_BIT]    = flags.ovr;
        end
    end

    assign dbg_rdata_o = dbg_rd_i ? data : '0;
    assign irq_o       = flags.rxf && irq_en_i;

    AST_DBG_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        dbg_rd_i && !buf_rd_i && !word_done_i && !rxf_clr_i && !ovr_clr_i && en_i
        |=> $stable(flags)); // R4

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> irq_en_i); // R10

endmodule

// File: tb/spi_rxbuf_status_test.sv
module spi_rxbuf_status_test;

    localparam int DATA_W = 16;
    localparam time PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en_i = 1'b0, irq_en_i = 1'b0, word_done_i = 1'b0;
    logic [DATA_W-1:0] word_i = '0;
    logic              buf_rd_i = 1'b0, dbg_rd_i = 1'b0, rxf_clr_i = 1'b0, ovr_clr_i = 1'b0;
    logic [DATA_W+1:0] buf_rdata_o;
    logic [DATA_W-1:0] dbg_rdata_o;
    logic              irq_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model
    logic [DATA_W-1:0] m_data;
    logic m_rxf, m_ovr, m_vld;
    logic [DATA_W+1:0] obs_buf;

    always #(PERIOD/2) clk = ~clk;

    spi_rxbuf_status #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .en_i(en_i), .irq_en_i(irq_en_i),
        .word_done_i(word_done_i), .word_i(word_i), .buf_rd_i(buf_rd_i),
        .dbg_rd_i(dbg_rd_i), .rxf_clr_i(rxf_clr_i), .ovr_clr_i(ovr_clr_i),
        .buf_rdata_o(buf_rdata_o), .dbg_rdata_o(dbg_rdata_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W+1:0] exp_buf(input logic rd);
        return rd ? {m_ovr, m_rxf, m_data} : '0;
    endfunction

    function automatic logic [DATA_W-1:0] exp_dbg(input logic rd);
        return rd ? m_data : '0;
    endfunction

    task automatic model_update();
        logic acc, set_ovr;
        acc = word_done_i && en_i;
        set_ovr = acc && m_vld && !buf_rd_i;
        if (!en_i) begin
            m_rxf = 0; m_ovr = 0;
        end else begin
            if (acc) m_rxf = 1; else if (buf_rd_i || rxf_clr_i) m_rxf = 0;
            if (set_ovr) m_ovr = 1; else if (buf_rd_i || ovr_clr_i) m_ovr = 0;
        end
        if (acc) m_vld = 1; else if (buf_rd_i) m_vld = 0;
        if (acc) m_data = word_i;
    endtask

    task automatic step(input logic en, input logic done, input logic [DATA_W-1:0] w,
                        input logic rd, input logic dbg, input logic rc, input logic oc,
                        input logic ie);
        @(negedge clk);
        en_i = en; word_done_i = done; word_i = w; buf_rd_i = rd;
        dbg_rd_i = dbg; rxf_clr_i = rc; ovr_clr_i = oc; irq_en_i = ie;
        #1;
        obs_buf = buf_rdata_o;
        check("R1 word", 32'(buf_rdata_o[DATA_W-1:0]), 32'(exp_buf(rd)[DATA_W-1:0]));
        check("R3 rxf image", 32'(buf_rdata_o[DATA_W]), 32'(exp_buf(rd)[DATA_W]));
        check("R5 ovr image", 32'(buf_rdata_o[DATA_W+1]), 32'(exp_buf(rd)[DATA_W+1]));
        check("R4 debug data", 32'(dbg_rdata_o), 32'(exp_dbg(dbg)));
        check("R10 irq", 32'(irq_o), 32'(m_rxf && ie));
        @(posedge clk);
        model_update();
    endtask

    task automatic idle_read();
        step(1, 0, '0, 1, 0, 0, 0, 1);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        m_data = '0; m_rxf = 0; m_ovr = 0; m_vld = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R11: reset state seen through a clearing read
        step(1, 0, '0, 1, 1, 0, 0, 1);
        check("R11 reset buffer", 32'(obs_buf), 32'h0);

        // R5: two words without a read
        step(1, 1, 16'h1111, 0, 0, 0, 0, 1);
        step(1, 1, 16'h2222, 0, 0, 0, 0, 1);
        idle_read();
        check("R5 overrun after unread word", 32'(obs_buf), 32'h3_2222);
        idle_read();
        check("R2 flags cleared by read", 32'(obs_buf), 32'h0_2222);

        // R4: debug reads do not clear
        step(1, 1, 16'hABCD, 0, 0, 0, 0, 0);
        step(1, 0, '0, 0, 1, 0, 0, 0);
        step(1, 0, '0, 0, 1, 0, 0, 0);
        idle_read();
        check("R4 rxf kept after debug reads", 32'(obs_buf), 32'h1_ABCD);

        // R6: disable/enable keeps the valid marker
        step(1, 1, 16'h0A0A, 0, 0, 0, 0, 1);
        step(0, 0, '0, 0, 0, 0, 0, 1);
        step(1, 1, 16'h0B0B, 0, 0, 0, 0, 1);
        idle_read();
        check("R6 spurious overrun", 32'(obs_buf), 32'h3_0B0B);
        // dummy read after re-enable avoids it
        step(1, 1, 16'h0C0C, 0, 0, 0, 0, 1);
        step(0, 0, '0, 0, 0, 0, 0, 1);
        step(1, 0, '0, 1, 0, 0, 0, 1);
        step(1, 1, 16'h0D0D, 0, 0, 0, 0, 1);
        idle_read();
        check("R6 dummy read prevents overrun", 32'(obs_buf), 32'h1_0D0D);

        // R8: disabled ignores words
        step(0, 1, 16'hDEAD, 0, 0, 0, 0, 1);
        step(1, 0, '0, 1, 0, 0, 0, 1);
        check("R8 word ignored when disabled", 32'(obs_buf), 32'h0_0D0D);

        // R9: read and word same cycle
        step(1, 1, 16'h4444, 0, 0, 0, 0, 1);
        step(1, 1, 16'h5555, 1, 0, 0, 0, 1);
        idle_read();
        check("R9 same-cycle read and word", 32'(obs_buf), 32'h1_5555);

        // R7: clears and set priority
        step(1, 1, 16'h6666, 0, 0, 0, 0, 1);
        step(1, 1, 16'h7777, 0, 0, 0, 0, 1);
        step(1, 0, '0, 0, 0, 1, 0, 1);
        idle_read();
        check("R7 rxf clear keeps ovr", 32'(obs_buf), 32'h2_7777);
        step(1, 1, 16'h8888, 0, 0, 1, 1, 1);
        idle_read();
        check("R7 set wins over clear", 32'(obs_buf), 32'h1_8888);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 10) != 0, ($urandom % 5) < 2, 16'($urandom),
                 ($urandom % 10) < 3, ($urandom % 2) == 1,
                 ($urandom % 10) == 0, ($urandom % 10) == 0, ($urandom % 2) == 1);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule